// File: doc/BRIEF.md
# Coincidence Trigger Former

This block builds the experiment trigger inside one synchronous clock domain, nominally 40 MHz. It takes four asynchronous detector pulses: a primary focal-plane timing pulse, a secondary detector pulse and two auxiliary inputs. Each pulse is synchronized and cut down to a one-cycle, clock-aligned pulse. The primary and secondary pulses are then paired into a coincidence when they arrive close enough in time. Because the logic is clocked, every output moves on clock edges, so its timing against the original pulse carries up to one clock period of jitter.

A five-bit enable selects which of the four single-source triggers and the coincidence trigger may fire. Every enabled trigger is ORed into a raw trigger. A live trigger is a raw trigger that occurs while the unit is not busy. The first live trigger raises busy, and busy stays high until an external clear pulse arrives. A run-enable level blocks every trigger output while it is low, which lets downstream counters be zeroed safely before a run starts.

Top module: `coinc_trigger_unit`

## Requirements
- R1: Every rising edge of a source input produces exactly one high cycle on its `src_pulse` bit, however long the input stays high. The pulse appears on the third rising clock edge after the first edge that samples the input high. Bit mapping: 0 primary, 1 secondary, 2 auxiliary 1, 3 auxiliary 2.
- R2: `trig_pulse[i]` goes high for one cycle, one clock after `src_pulse[i]`, when `enable_mask[i]` is 1 and `run_en` is 1. Otherwise it stays low.
- R3: A coincidence is declared when the primary and secondary source pulses are separated by no more than W cycles, in either order. W is `window_cfg`, and a value of 0 counts as 1. When `enable_mask[4]` and `run_en` are both 1, each coincidence gives exactly one `coinc_trig` pulse, two cycles after the later source pulse.
- R4: A pulse that has formed a coincidence cannot take part in another one. A third pulse inside the window after a matched pair therefore adds no coincidence.
- R5: `raw_trig` is high in exactly those cycles in which any `trig_pulse` bit or `coinc_trig` is high.
- R6: While `run_en` is 0, `trig_pulse`, `coinc_trig`, `raw_trig` and `live_trig` stay low. `src_pulse` keeps working.
- R7: `live_trig` equals `raw_trig` while `busy` is low. A live trigger sets `busy`. While `busy` is high, raw triggers produce no live trigger.
- R8: `busy` stays high until a `clear_busy` cycle, after which it reads low on the next cycle.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trigger clock |
| rst | input | 1 | Synchronous active-high reset |
| primary_in | input | 1 | Asynchronous primary timing pulse |
| secondary_in | input | 1 | Asynchronous secondary detector pulse |
| ext1_in | input | 1 | Asynchronous auxiliary input 1 |
| ext2_in | input | 1 | Asynchronous auxiliary input 2 |
| run_en | input | 1 | Run-enable level; 0 blocks all triggers |
| clear_busy | input | 1 | Busy release pulse |
| window_cfg | input | 4 | Coincidence window in cycles (0 counts as 1) |
| enable_mask | input | 5 | Trigger enables: bits 0-3 single sources, bit 4 coincidence |
| src_pulse | output | 4 | Conditioned one-cycle source pulses |
| trig_pulse | output | 4 | Gated single-source trigger pulses |
| coinc_trig | output | 1 | Gated coincidence trigger pulse |
| raw_trig | output | 1 | OR of all gated triggers |
| live_trig | output | 1 | Raw trigger taken while not busy |
| busy | output | 1 | Busy level after a live trigger |

## Verification
Primary/secondary pairs are driven with random separations and windows on both sides of the boundary. Directed pairs sit at separations exactly W and W+1, at zero separation, and at a window setting of 0. Together these separate an inclusive window from an exclusive or off-by-one one. A matched pair followed by a third secondary pulse shows whether matched pulses are consumed. A long-held input separates edge detection from level passing. A masked source, a dropped run-enable and repeated triggers around a busy clear separate the masking, run gating and busy paths from one another.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
    localparam int NUM_SRC   = 4;
    localparam int WIN_BITS  = 4;
    localparam int MASK_BITS = NUM_SRC + 1;

    typedef enum logic [1:0] {
        SRC_PRIMARY   = 2'd0,
        SRC_SECONDARY = 2'd1,
        SRC_AUX1      = 2'd2,
        SRC_AUX2      = 2'd3
    } src_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] single;
        logic               coinc;
    } trig_vec_t;

    function automatic logic [WIN_BITS-1:0] eff_window(input logic [WIN_BITS-1:0] w);
        return (w == '0) ? WIN_BITS'(1) : w;
    endfunction
endpackage

// File: rtl/ctu_conditioner.sv
module ctu_conditioner #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
            pulse  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            last_q <= sync_q[SYNC_STAGES-1];
            pulse  <= sync_q[SYNC_STAGES-1] & ~last_q;
        end
    end

    // R1: a conditioned pulse lasts exactly one cycle
    a_r1_single_cycle: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/ctu_coinc.sv
module ctu_coinc
    import ctu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                p_pulse,
    input  logic                s_pulse,
    input  logic [WIN_BITS-1:0] window_cfg,
    output logic                hit
);
    logic [WIN_BITS-1:0] p_left, s_left, win;
    logic                p_armed, s_armed, match;

    assign win     = eff_window(window_cfg);
    assign p_armed = (p_left != '0);
    assign s_armed = (s_left != '0);
    assign match   = (p_pulse && (s_pulse || s_armed)) || (s_pulse && p_armed);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_left <= '0;
            s_left <= '0;
            hit    <= 1'b0;
        end else begin
            hit <= match;
            if (match) begin
                p_left <= '0;
                s_left <= '0;
            end else begin
                if (p_pulse)      p_left <= win;
                else if (p_armed) p_left <= p_left - 1'b1;
                if (s_pulse)      s_left <= win;
                else if (s_armed) s_left <= s_left - 1'b1;
            end
        end
    end

    // R4: a match leaves no arm pending
    a_r4_arms_consumed: assert property (@(posedge clk) disable iff (rst)
        hit |-> (!p_armed && !s_armed));
    // R3: coincidences never come on back-to-back cycles
    a_r3_hit_single: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);
endmodule

// File: rtl/ctu_gate.sv
module ctu_gate
    import ctu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   src,
    input  logic                 coinc_hit,
    input  logic [MASK_BITS-1:0] mask,
    input  logic                 run_en,
    input  logic                 clear_busy,
    output trig_vec_t            trig_q,
    output logic                 raw_q,
    output logic                 live_q,
    output logic                 busy_q
);
    trig_vec_t trig_n;
    logic      raw_n, live_n;

    always_comb begin
        trig_n.single = src & mask[NUM_SRC-1:0] & {NUM_SRC{run_en}};
        trig_n.coinc  = coinc_hit & mask[NUM_SRC] & run_en;
        raw_n         = (|trig_n.single) | trig_n.coinc;
        live_n        = raw_n & ~busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            raw_q  <= 1'b0;
            live_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            trig_q <= trig_n;
            raw_q  <= raw_n;
            live_q <= live_n;
            if (live_n)          busy_q <= 1'b1;
            else if (clear_busy) busy_q <= 1'b0;
        end
    end

    // R6: no trigger follows a cycle with run-enable low
    a_r6_run_gate: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!raw_q && !live_q));
    // R7: a live trigger is always a raw trigger and leaves busy set
    a_r7_live_is_raw: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (raw_q && busy_q));
    // R7: busy blocks the next live trigger
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !live_q);
    // R8: busy holds until cleared
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !clear_busy) |=> busy_q);
endmodule

// File: rtl/coinc_trigger_unit.sv
module coinc_trigger_unit
    import ctu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 primary_in,
    input  logic                 secondary_in,
    input  logic                 ext1_in,
    input  logic                 ext2_in,
    input  logic                 run_en,
    input  logic                 clear_busy,
    input  logic [WIN_BITS-1:0]  window_cfg,
    input  logic [MASK_BITS-1:0] enable_mask,
    output logic [NUM_SRC-1:0]   src_pulse,
    output logic [NUM_SRC-1:0]   trig_pulse,
    output logic                 coinc_trig,
    output logic                 raw_trig,
    output logic                 live_trig,
    output logic                 busy
);
    logic [NUM_SRC-1:0] raw_in;
    logic               coinc_hit;
    trig_vec_t          trig_q;

    assign raw_in = {ext2_in, ext1_in, secondary_in, primary_in};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cond
        ctu_conditioner #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[i]),
            .pulse(src_pulse[i])
        );
    end

    ctu_coinc u_coinc (
        .clk       (clk),
        .rst       (rst),
        .p_pulse   (src_pulse[SRC_PRIMARY]),
        .s_pulse   (src_pulse[SRC_SECONDARY]),
        .window_cfg(window_cfg),
        .hit       (coinc_hit)
    );

    ctu_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .src       (src_pulse),
        .coinc_hit (coinc_hit),
        .mask      (enable_mask),
        .run_en    (run_en),
        .clear_busy(clear_busy),
        .trig_q    (trig_q),
        .raw_q     (raw_trig),
        .live_q    (live_trig),
        .busy_q    (busy)
    );

    assign trig_pulse = trig_q.single;
    assign coinc_trig = trig_q.coinc;
endmodule

// File: tb/coinc_trigger_unit_test.sv
`timescale 1ns/100ps
module coinc_trigger_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src_in = '0;
    logic       run_en = 1'b0;
    logic       clear_busy = 1'b0;
    logic [3:0] window_cfg = 4'd4;
    logic [4:0] enable_mask = '0;
    logic [3:0] src_pulse, trig_pulse;
    logic       coinc_trig, raw_trig, live_trig, busy;

    int checks = 0, fails = 0;
    int n_src0 = 0, n_src2 = 0, n_trig2 = 0, n_coinc = 0, n_raw = 0, n_live = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    coinc_trigger_unit uut (
        .clk(clk), .rst(rst),
        .primary_in(src_in[0]), .secondary_in(src_in[1]),
        .ext1_in(src_in[2]), .ext2_in(src_in[3]),
        .run_en(run_en), .clear_busy(clear_busy),
        .window_cfg(window_cfg), .enable_mask(enable_mask),
        .src_pulse(src_pulse), .trig_pulse(trig_pulse),
        .coinc_trig(coinc_trig), .raw_trig(raw_trig),
        .live_trig(live_trig), .busy(busy)
    );

    always @(negedge clk) begin
        n_src0  += int'(src_pulse[0]);
        n_src2  += int'(src_pulse[2]);
        n_trig2 += int'(trig_pulse[2]);
        n_coinc += int'(coinc_trig);
        n_raw   += int'(raw_trig);
        n_live  += int'(live_trig);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    function automatic int exp_coinc(input int w, input int dt);
        int ew = (w == 0) ? 1 : w;
        int a = (dt < 0) ? -dt : dt;
        return (a <= ew) ? 1 : 0;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk); clear_busy = 1'b1;
        @(negedge clk); clear_busy = 1'b0;
    endtask

    task automatic pulse_src(input int idx, input int hold);
        @(negedge clk); src_in[idx] = 1'b1;
        idle(hold);
        src_in[idx] = 1'b0;
        idle(12);
    endtask

    // primary at cycle tp, secondary at ts, each held 3 cycles
    task automatic run_pair(input int w, input int dt);
        int tp = (dt < 0) ? -dt : 0;
        int ts = (dt < 0) ? 0 : dt;
        int span = ((tp > ts) ? tp : ts) + 3;
        int c0, r0;
        window_cfg = 4'(w);
        enable_mask = 5'b10000;
        do_clear();
        idle(2);
        c0 = n_coinc; r0 = n_raw;
        for (int c = 0; c <= span; c++) begin
            @(negedge clk);
            src_in[0] = (c >= tp && c < tp + 3);
            src_in[1] = (c >= ts && c < ts + 3);
        end
        idle(30);
        check($sformatf("R3 coinc w=%0d dt=%0d", w, dt), n_coinc - c0, exp_coinc(w, dt));
        check($sformatf("R5 raw w=%0d dt=%0d", w, dt), n_raw - r0, exp_coinc(w, dt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int unsigned seed;
        int b0, b1, b2;
        seed = $urandom(32'd20251);
        idle(3);
        @(negedge clk); rst = 1'b0;
        // R9 reset state
        check("R9 outputs after reset",
              int'({src_pulse, trig_pulse, coinc_trig, raw_trig, live_trig, busy}), 0);

        // R1/R2 latency and single pulse on a long hold
        run_en = 1'b1; enable_mask = 5'b00001;
        @(negedge clk); src_in[0] = 1'b1;   // first sampled at next edge
        @(negedge clk);
        @(negedge clk);
        check("R1 no pulse before third edge", int'(src_pulse[0]), 0);
        @(negedge clk);
        check("R1 pulse at third edge", int'(src_pulse[0]), 1);
        @(negedge clk);
        check("R1 pulse one cycle wide", int'(src_pulse[0]), 0);
        check("R2 trig one cycle later", int'(trig_pulse[0]), 1);
        check("R5 raw with single trig", int'(raw_trig), 1);
        check("R7 live when idle", int'(live_trig), 1);
        b0 = n_src0;
        idle(20);
        src_in[0] = 1'b0;
        idle(5);
        check("R1 long hold one pulse", n_src0 - b0, 0);
        check("R7 busy after live", int'(busy), 1);

        // R8 clear, R7 busy blocking
        do_clear();
        @(negedge clk);
        check("R8 busy cleared", int'(busy), 0);
        b1 = n_raw; b2 = n_live;
        pulse_src(0, 3);
        pulse_src(0, 3);
        check("R7 raw while busy", n_raw - b1, 2);
        check("R7 live blocked while busy", n_live - b2, 1);
        check("R8 busy held without clear", int'(busy), 1);
        do_clear();
        b2 = n_live;
        pulse_src(0, 3);
        check("R7 live after clear", n_live - b2, 1);

        // R2 masked source
        enable_mask = 5'b00001; do_clear();
        b0 = n_src2; b1 = n_trig2; b2 = n_raw;
        pulse_src(2, 2);
        check("R2 masked src still seen", n_src2 - b0, 1);
        check("R2 masked trig absent", n_trig2 - b1, 0);
        check("R5 masked raw absent", n_raw - b2, 0);
        enable_mask = 5'b00100;
        b1 = n_trig2;
        pulse_src(2, 2);
        check("R2 enabled aux trig", n_trig2 - b1, 1);

        // R6 run-enable low
        run_en = 1'b0; enable_mask = 5'b11111; window_cfg = 4'd5; do_clear();
        b0 = n_src0; b1 = n_raw; b2 = n_live;
        @(negedge clk); src_in[1:0] = 2'b11;
        idle(3); src_in[1:0] = 2'b00;
        idle(20);
        check("R6 src unaffected", n_src0 - b0, 1);
        check("R6 no raw", n_raw - b1, 0);
        check("R6 no live", n_live - b2, 0);
        check("R6 no trig bits", int'(trig_pulse), 0);
        run_en = 1'b1;

        // R3 directed boundaries
        run_pair(4, 4);
        run_pair(4, -5);
        run_pair(4, 0);
        run_pair(0, 1);
        run_pair(0, -2);
        run_pair(15, -15);
        run_pair(15, 16);

        // R4 third pulse after a matched pair
        window_cfg = 4'd8; enable_mask = 5'b10000; do_clear();
        b0 = n_coinc;
        @(negedge clk); src_in[0] = 1'b1;
        idle(2); src_in[1] = 1'b1;
        idle(2); src_in = '0;
        idle(2); src_in[1] = 1'b1;
        idle(2); src_in = '0;
        idle(30);
        check("R4 matched pulse not reused", n_coinc - b0, 1);

        // R3 random pairs
        for (int k = 0; k < 40; k++) begin
            int w = int'($urandom_range(0, 15));
            int dt = int'($urandom_range(0, 40)) - 20;
            run_pair(w, dt);
        end
        finish_run();
    end
endmodule